// File: doc/BRIEF.md
# Capability Fault Prioritizer and Trap-Value Encoder

This block sits next to the trap logic of a capability-checking core. The check units of one instruction can flag several capability violations in the same cycle. The block takes all of those flags, together with the kind of access being performed and a 6-bit register identifier. It picks the one violation that architecture rules say must be reported. It then forms the trap cause and a packed trap-value word that names both the violation and the offending register.

Capability page faults on capability loads and stores do not use the capability trap-value encoding. They are reported with their own cause codes and take precedence over any violation flags.

The result is captured when the exception strobe is high. It stays unchanged until the next strobe, so the trap-entry logic can read it over several cycles.

Top module: `cap_fault_prioritizer`

## Requirements
- R1: Flag bits of `viol_i`:
  - bit 0 length
  - bit 1 tag
  - bit 2 seal
  - bit 3 type
  - bit 4 software-defined permission
  - bit 5 global
  - bit 6 execute
  - bit 7 load
  - bit 8 store
  - bit 9 load-capability
  - bit 10 store-capability
  - bit 11 store-local-capability
  - bit 12 system-register access
  - bit 13 invoke
  - bit 14 compartment-ID

  A lone flag yields trap cause 0x1C and, in trap-value bits [4:0], its violation code. The codes are length 0x01, tag 0x02, seal 0x03, type 0x04, software 0x08, global 0x10, execute 0x11, load 0x12, store 0x13, load-cap 0x14, store-cap 0x15, store-local 0x16, system-register 0x18, invoke 0x19, compartment-ID 0x1C.
- R2: With several flags set, the reported violation is the one at the highest priority level. The levels, highest first, are:
  1. system-register
  2. tag
  3. seal
  4. type
  5. invoke / compartment-ID
  6. execute
  7. load / store
  8. load-cap / store-cap
  9. store-local
  10. global
  11. length
  12. software permission
- R3: When both flags of a shared level are set, `acc_kind_i` decides which one is reported. Its encoding is 0 load, 1 store, 2 invoke, 3 other.
  - At the load/store and load-cap/store-cap levels, the store member wins when the value is 1; otherwise the load member wins.
  - At the invoke/compartment-ID level, invoke wins when the value is 2; otherwise compartment-ID wins.
- R4: The trap value holds the violation code in bits [4:0] and `reg_idx_i` in bits [10:5], so bit 10 is the file select (1 = special register, 0 = general register). All bits above 10 are zero.
- R5: `cap_ld_pf_i` gives trap cause 0x1A and `cap_st_pf_i` gives 0x1B, both with a zero trap value. Either one overrides any violation flags, and the load fault wins if both are set.
- R6: With no flags and no page fault, the strobe captures trap cause 0x00 and trap value 0.
- R7: Outputs change only at a clock edge where `exc_strobe_i` is high. Otherwise they hold, whatever the other inputs do.
- R8: Synchronous active-high `rst` clears the trap cause and trap value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_strobe_i | input | 1 | Capture strobe for a new exception |
| viol_i | input | 15 | Simultaneous violation flags (R1 bit map) |
| acc_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 invoke, 3 other |
| reg_idx_i | input | 6 | Offending register; bit 5 selects special file |
| cap_ld_pf_i | input | 1 | Capability-load page fault |
| cap_st_pf_i | input | 1 | Capability-store page fault |
| trap_cause_o | output | 5 | Captured trap cause |
| trap_val_o | output | TVAL_W (32) | Captured packed trap value |

## Verification
The hardest case to reach is the one where both members of a shared priority level are flagged, the access kind decides between them, and no higher-level flag masks the outcome. Random flag vectors rarely produce that by chance. Directed cases therefore set exactly those pairs under each access kind. They also sweep each level with every lower-priority flag set at the same time. Sparse random vectors, formed by AND-ing several random words, then mix in page faults and register indices of both files.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam int NUM_FLAGS  = 15;
    localparam int NUM_LEVELS = 12;
    localparam int CODE_W     = 5;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_INVOKE = 2'd2,
        ACC_OTHER  = 2'd3
    } acc_kind_e;

    // violation codes carried in the low trap-value field
    localparam logic [CODE_W-1:0] VC_NONE   = 5'h00;
    localparam logic [CODE_W-1:0] VC_LEN    = 5'h01;
    localparam logic [CODE_W-1:0] VC_TAG    = 5'h02;
    localparam logic [CODE_W-1:0] VC_SEAL   = 5'h03;
    localparam logic [CODE_W-1:0] VC_TYPE   = 5'h04;
    localparam logic [CODE_W-1:0] VC_SWPERM = 5'h08;
    localparam logic [CODE_W-1:0] VC_GLOB   = 5'h10;
    localparam logic [CODE_W-1:0] VC_EXEC   = 5'h11;
    localparam logic [CODE_W-1:0] VC_LD     = 5'h12;
    localparam logic [CODE_W-1:0] VC_ST     = 5'h13;
    localparam logic [CODE_W-1:0] VC_LDCAP  = 5'h14;
    localparam logic [CODE_W-1:0] VC_STCAP  = 5'h15;
    localparam logic [CODE_W-1:0] VC_STLOC  = 5'h16;
    localparam logic [CODE_W-1:0] VC_SYSREG = 5'h18;
    localparam logic [CODE_W-1:0] VC_INVOKE = 5'h19;
    localparam logic [CODE_W-1:0] VC_CID    = 5'h1C;

    // trap causes
    localparam logic [CODE_W-1:0] TC_NONE    = 5'h00;
    localparam logic [CODE_W-1:0] TC_CAPLDPF = 5'h1A;
    localparam logic [CODE_W-1:0] TC_CAPSTPF = 5'h1B;
    localparam logic [CODE_W-1:0] TC_CAPVIOL = 5'h1C;

    // flag bit positions in the violation vector
    localparam int F_LEN    = 0;
    localparam int F_TAG    = 1;
    localparam int F_SEAL   = 2;
    localparam int F_TYPE   = 3;
    localparam int F_SWPERM = 4;
    localparam int F_GLOB   = 5;
    localparam int F_EXEC   = 6;
    localparam int F_LD     = 7;
    localparam int F_ST     = 8;
    localparam int F_LDCAP  = 9;
    localparam int F_STCAP  = 10;
    localparam int F_STLOC  = 11;
    localparam int F_SYSREG = 12;
    localparam int F_INVOKE = 13;
    localparam int F_CID    = 14;

    // level 4 is the only shared level steered by invoke
    localparam int LVL_INVOKE_PAIR = 4;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } pick_t;

    // first member of a priority level (level 0 is highest)
    function automatic int lvl_flag_a(input int l);
        case (l)
            0:       return F_SYSREG;
            1:       return F_TAG;
            2:       return F_SEAL;
            3:       return F_TYPE;
            4:       return F_INVOKE;
            5:       return F_EXEC;
            6:       return F_LD;
            7:       return F_LDCAP;
            8:       return F_STLOC;
            9:       return F_GLOB;
            10:      return F_LEN;
            default: return F_SWPERM;
        endcase
    endfunction

    // second member; equals the first on unshared levels
    function automatic int lvl_flag_b(input int l);
        case (l)
            4:       return F_CID;
            6:       return F_ST;
            7:       return F_STCAP;
            default: return lvl_flag_a(l);
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] flag_code(input int f);
        case (f)
            F_LEN:    return VC_LEN;
            F_TAG:    return VC_TAG;
            F_SEAL:   return VC_SEAL;
            F_TYPE:   return VC_TYPE;
            F_SWPERM: return VC_SWPERM;
            F_GLOB:   return VC_GLOB;
            F_EXEC:   return VC_EXEC;
            F_LD:     return VC_LD;
            F_ST:     return VC_ST;
            F_LDCAP:  return VC_LDCAP;
            F_STCAP:  return VC_STCAP;
            F_STLOC:  return VC_STLOC;
            F_SYSREG: return VC_SYSREG;
            F_INVOKE: return VC_INVOKE;
            default:  return VC_CID;
        endcase
    endfunction

    // on a tie within a shared level, does the second member win?
    function automatic logic lvl_prefers_b(input int l, input acc_kind_e acc);
        if (l == LVL_INVOKE_PAIR) return acc != ACC_INVOKE;
        return acc == ACC_STORE;
    endfunction

endpackage

// File: rtl/cfp_level_pick.sv
module cfp_level_pick
    import cfp_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] viol_i,
    input  acc_kind_e            acc_i,
    output pick_t                pick_o
);

    logic [NUM_LEVELS-1:0] hit;
    logic [NUM_LEVELS-1:0] win;
    logic [CODE_W-1:0]     lvl_code [NUM_LEVELS];

    generate
        for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
            localparam int                FA = lvl_flag_a(l);
            localparam int                FB = lvl_flag_b(l);
            localparam logic [CODE_W-1:0] CA = flag_code(FA);
            localparam logic [CODE_W-1:0] CB = flag_code(FB);
            logic fa, fb, take_b;
            assign fa          = viol_i[FA];
            assign fb          = viol_i[FB];
            assign take_b      = fb & (~fa | lvl_prefers_b(l, acc_i));
            assign hit[l]      = fa | fb;
            assign lvl_code[l] = take_b ? CB : CA;
        end
    endgenerate

    // level 0 has the highest priority
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            win[l] = hit[l] & ~seen;
            seen   = seen | hit[l];
        end
    end

    always_comb begin
        pick_o.valid = |win;
        pick_o.code  = VC_NONE;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            pick_o.code = pick_o.code | ({CODE_W{win[l]}} & lvl_code[l]);
        end
    end

    always_comb begin
        if (!$isunknown(viol_i)) begin
            a_r2_single_winner: assert ($onehot0(win));
            a_r1_flag_gives_code: assert (!(|viol_i) || pick_o.code != VC_NONE);
        end
    end

endmodule

// File: rtl/cfp_tval_pack.sv
module cfp_tval_pack
    import cfp_pkg::*;
#(
    parameter int TVAL_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [TVAL_W-1:0] tval_o
);

    localparam int USED_W = CODE_W + IDX_W;

    always_comb begin
        tval_o             = '0;
        tval_o[USED_W-1:0] = {idx_i, code_i};
    end

endmodule

// File: rtl/cap_fault_prioritizer.sv
module cap_fault_prioritizer
    import cfp_pkg::*;
#(
    parameter int TVAL_W    = 32,
    parameter int REG_SEL_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 exc_strobe_i,
    input  logic [14:0]          viol_i,
    input  logic [1:0]           acc_kind_i,
    input  logic [REG_SEL_W:0]   reg_idx_i,
    input  logic                 cap_ld_pf_i,
    input  logic                 cap_st_pf_i,
    output logic [CODE_W-1:0]    trap_cause_o,
    output logic [TVAL_W-1:0]    trap_val_o
);

    localparam int IDX_W  = REG_SEL_W + 1;
    localparam int USED_W = CODE_W + IDX_W;

    acc_kind_e         acc;
    pick_t             pick;
    logic [TVAL_W-1:0] tval_packed;
    logic [CODE_W-1:0] cause_nxt;
    logic [TVAL_W-1:0] tval_nxt;

    assign acc = acc_kind_e'(acc_kind_i);

    cfp_level_pick u_pick (
        .viol_i (viol_i),
        .acc_i  (acc),
        .pick_o (pick)
    );

    cfp_tval_pack #(
        .TVAL_W (TVAL_W),
        .IDX_W  (IDX_W)
    ) u_pack (
        .code_i (pick.code),
        .idx_i  (reg_idx_i),
        .tval_o (tval_packed)
    );

    always_comb begin
        cause_nxt = TC_NONE;
        tval_nxt  = '0;
        if (cap_ld_pf_i) begin
            cause_nxt = TC_CAPLDPF;
        end else if (cap_st_pf_i) begin
            cause_nxt = TC_CAPSTPF;
        end else if (pick.valid) begin
            cause_nxt = TC_CAPVIOL;
            tval_nxt  = tval_packed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_cause_o <= TC_NONE;
            trap_val_o   <= '0;
        end else if (exc_strobe_i) begin
            trap_cause_o <= cause_nxt;
            trap_val_o   <= tval_nxt;
        end
    end

    a_r5_pf_no_tval: assert property (@(posedge clk) disable iff (rst)
        (trap_cause_o == TC_CAPLDPF || trap_cause_o == TC_CAPSTPF) |-> trap_val_o == '0);

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (trap_cause_o == TC_NONE) |-> trap_val_o == '0);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !exc_strobe_i |=> ($stable(trap_cause_o) && $stable(trap_val_o)));

    a_r1_capviol_has_code: assert property (@(posedge clk) disable iff (rst)
        (trap_cause_o == TC_CAPVIOL) |-> trap_val_o[CODE_W-1:0] != VC_NONE);

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (trap_val_o >> USED_W) == '0);

    a_r5_pf_wins: assert property (@(posedge clk) disable iff (rst)
        (exc_strobe_i && cap_ld_pf_i) |=> trap_cause_o == TC_CAPLDPF);

endmodule

// File: tb/tb_cap_fault_prioritizer.sv
module tb_cap_fault_prioritizer;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_strobe_i;
    logic [14:0] viol_i;
    logic [1:0]  acc_kind_i;
    logic [5:0]  reg_idx_i;
    logic        cap_ld_pf_i;
    logic        cap_st_pf_i;
    logic [4:0]  trap_cause_o;
    logic [31:0] trap_val_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cap_fault_prioritizer dut (
        .clk          (clk),
        .rst          (rst),
        .exc_strobe_i (exc_strobe_i),
        .viol_i       (viol_i),
        .acc_kind_i   (acc_kind_i),
        .reg_idx_i    (reg_idx_i),
        .cap_ld_pf_i  (cap_ld_pf_i),
        .cap_st_pf_i  (cap_st_pf_i),
        .trap_cause_o (trap_cause_o),
        .trap_val_o   (trap_val_o)
    );

    function automatic logic [4:0] ref_code(input logic [14:0] v, input logic [1:0] a);
        if (v[12]) return 5'h18;
        if (v[1])  return 5'h02;
        if (v[2])  return 5'h03;
        if (v[3])  return 5'h04;
        if (v[13] && v[14]) return (a == 2'd2) ? 5'h19 : 5'h1C;
        if (v[13]) return 5'h19;
        if (v[14]) return 5'h1C;
        if (v[6])  return 5'h11;
        if (v[7] && v[8]) return (a == 2'd1) ? 5'h13 : 5'h12;
        if (v[7])  return 5'h12;
        if (v[8])  return 5'h13;
        if (v[9] && v[10]) return (a == 2'd1) ? 5'h15 : 5'h14;
        if (v[9])  return 5'h14;
        if (v[10]) return 5'h15;
        if (v[11]) return 5'h16;
        if (v[5])  return 5'h10;
        if (v[0])  return 5'h01;
        if (v[4])  return 5'h08;
        return 5'h00;
    endfunction

    function automatic logic [4:0] ref_cause(input logic [14:0] v, input logic lp, input logic sp);
        if (lp) return 5'h1A;
        if (sp) return 5'h1B;
        if (v != 0) return 5'h1C;
        return 5'h00;
    endfunction

    function automatic logic [31:0] ref_tval(input logic [14:0] v, input logic [1:0] a,
                                             input logic [5:0] idx, input logic lp, input logic sp);
        if (lp || sp || v == 0) return 32'h0;
        return {21'h0, idx, ref_code(v, a)};
    endfunction

    task automatic check(input string req, input logic [4:0] ec, input logic [31:0] ev);
        checks++;
        if (trap_cause_o !== ec || trap_val_o !== ev) begin
            errors++;
            $display("FAIL %s cause=%h expected %h tval=%h expected %h",
                     req, trap_cause_o, ec, trap_val_o, ev);
        end
    endtask

    // strobe a fault, then check the captured result away from the edge
    task automatic fire(input string req, input logic [14:0] v, input logic [1:0] a,
                        input logic [5:0] idx, input logic lp, input logic sp);
        @(negedge clk);
        viol_i = v; acc_kind_i = a; reg_idx_i = idx;
        cap_ld_pf_i = lp; cap_st_pf_i = sp; exc_strobe_i = 1'b1;
        @(negedge clk);
        exc_strobe_i = 1'b0;
        check(req, ref_cause(v, lp, sp), ref_tval(v, a, idx, lp, sp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0]  hold_c;
        logic [31:0] hold_v;
        rst = 1'b1; exc_strobe_i = 1'b0; viol_i = '0; acc_kind_i = 2'd0;
        reg_idx_i = '0; cap_ld_pf_i = 1'b0; cap_st_pf_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset state", 5'h00, 32'h0);
        rst = 1'b0;

        // R1 and R4: every flag alone, general and special file indices
        for (int f = 0; f < 15; f++) begin
            fire("R1 single flag", 15'(1 << f), 2'd3, 6'(f + 7), 1'b0, 1'b0);
            fire("R4 special file index", 15'(1 << f), 2'd0, 6'h20 | 6'(f), 1'b0, 1'b0);
        end
        fire("R4 top index", 15'h0010, 2'd3, 6'h3F, 1'b0, 1'b0);

        // R2: each level with all lower-priority flags also raised
        begin
            int order [12] = '{12, 1, 2, 3, 13, 6, 7, 9, 11, 5, 0, 4};
            for (int l = 0; l < 12; l++) begin
                logic [14:0] v;
                v = '0;
                for (int k = l; k < 12; k++) v[order[k]] = 1'b1;
                fire("R2 priority sweep", v, 2'd3, 6'(l), 1'b0, 1'b0);
            end
        end
        fire("R2 all flags", 15'h7FFF, 2'd1, 6'h11, 1'b0, 1'b0);

        // R3: tied pairs under every access kind
        for (int a = 0; a < 4; a++) begin
            fire("R3 load/store tie",      15'h0180, 2'(a), 6'h05, 1'b0, 1'b0);
            fire("R3 ldcap/stcap tie",     15'h0600, 2'(a), 6'h25, 1'b0, 1'b0);
            fire("R3 invoke/cid tie",      15'h6000, 2'(a), 6'h0A, 1'b0, 1'b0);
            fire("R3 tie under lower",     15'h0621, 2'(a), 6'h0B, 1'b0, 1'b0);
        end

        // R5: page faults
        fire("R5 cap load page fault",  15'h0000, 2'd0, 6'h03, 1'b1, 1'b0);
        fire("R5 cap store page fault", 15'h0000, 2'd1, 6'h03, 1'b0, 1'b1);
        fire("R5 both page faults",     15'h0000, 2'd1, 6'h03, 1'b1, 1'b1);
        fire("R5 fault over flags",     15'h7FFF, 2'd1, 6'h3F, 1'b0, 1'b1);

        // R6: nothing flagged
        fire("R6 idle capture", 15'h0000, 2'd2, 6'h2A, 1'b0, 1'b0);

        // R7: inputs move without strobe, outputs must hold
        fire("R7 setup", 15'h0002, 2'd0, 6'h21, 1'b0, 1'b0);
        hold_c = trap_cause_o; hold_v = trap_val_o;
        @(negedge clk);
        viol_i = 15'h1000; cap_ld_pf_i = 1'b1; reg_idx_i = 6'h3F;
        repeat (3) @(negedge clk);
        check("R7 hold without strobe", hold_c, hold_v);
        cap_ld_pf_i = 1'b0;

        // R8: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset after capture", 5'h00, 32'h0);

        // random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [14:0] v;
            logic        lp, sp;
            v  = 15'($urandom & $urandom & $urandom);
            lp = ($urandom % 16) == 0;
            sp = ($urandom % 16) == 0;
            fire("R2 random", v, 2'($urandom), 6'($urandom), lp, sp);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule